// File: doc/BRIEF.md
# SPI Configuration Target Command Responder

This block is the target side of a byte-framed SPI configuration port. A host opens a frame by raising chip select and sends bytes. The first byte of each frame is an opcode, and every command is four bytes long. The block decodes the command, keeps a 32-bit status word, and presents that word back to the host when asked. It commits 16-byte pages to an on-chip memory through a write port. The page address steps forward by one after each page.

Erase, program-done and refresh take time in the real device. Here a busy timer models that time. While the timer runs, the BUSY flag is set and any new command other than read-status is refused. A frame that ends before its command is complete is thrown away and recorded as an overflow error. The bit positions of the status word are fixed, because host software decodes them.

Top module: `cfgport_target`

## Requirements
- R1: After reset, `status_o` equals `DEV_VER<<27`. BUSY, DONE, enable and the error code are all zero. No memory write or clear is issued, and `tx_byte_o` is 0.
- R2: A byte is accepted when `cs_i` and `rx_valid_i` are both high. The first accepted byte of a frame is the opcode, and the command acts when its 4th byte is accepted. The opcodes are C6 enable, 0E erase, 46 init-address, 70 program-page, 5E program-done, 3C read-status and 79 refresh. Any other opcode sets the error code to 2.
- R3: The status word has BUSY at bit 12, DONE at bit 8, enable at bit 9, FAIL at bit 13 and the device-version flag at bit 27. The error code sits in bits 25:23 (0 none, 2 command, 6 overflow). FAIL is high whenever the error code is not 0.
- R4: After the 4th byte of a read-status command, `tx_byte_o` holds status bits 31:24, sampled at that byte. Each of the next three accepted bytes shifts the next lower byte out, MSB first. `tx_byte_o` is 0 outside this window.
- R5: Enable sets bit 9 and clears the error code. Erase, program-page, program-done and refresh are refused while bit 9 is clear. A refused command sets error code 2 and has no other effect.
- R6: A command other than read-status that completes while BUSY is high is dropped and sets error code 2.
- R7: Erase issues a one-cycle `mem_clr_o` pulse and clears DONE. BUSY then stays high for exactly `ERASE_CYC` cycles.
- R8: A program-page frame carries 16 data bytes after its 4 command bytes. The last data byte causes one write of the page: data byte k goes to `mem_wdata_o[8k+7:8k]` and the address is the current page. The page then advances by one.
- R9: Init-address sets the page address to 0.
- R10: Program-done holds BUSY for `PROG_CYC` cycles and then sets DONE.
- R11: Refresh holds BUSY for `REFRESH_CYC` cycles and then clears bit 9. DONE is kept.
- R12: A frame that ends with at least one byte but fewer than its required length is discarded and sets error code 6. The required length is 20 bytes for program-page, 8 for read-status and 4 for all other opcodes. A frame with no bytes changes nothing.
- R13: When a busy interval expires on the same clock edge as a short frame ends, both the expiry action and error code 6 take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Frame active (chip select asserted) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Byte returned to the host |
| mem_we_o | output | 1 | Page write strobe |
| mem_addr_o | output | PAGE_AW | Page address of the write |
| mem_wdata_o | output | PAGE_BYTES*8 | Page data, byte 0 in the low bits |
| mem_clr_o | output | 1 | Memory clear pulse |
| status_o | output | 32 | Status word |
| busy_o | output | 1 | Busy flag |
| done_o | output | 1 | Done flag |
| cfg_en_o | output | 1 | Configuration enabled flag |
| err_o | output | 3 | Error code |

## Verification
The busy timer's expiry and the frame tracker's short-frame detection can both write the status word on one clock edge. The expiry clears the enable flag after a refresh, and the short frame sets the error field. To provoke this, the bench starts a refresh and counts cycles from its final command byte. It then opens a one-byte frame and drops chip select in the last busy cycle. It first confirms that BUSY is still high at that moment. After the shared edge, it expects enable cleared, DONE kept and error code 6, all together.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int CMD_BYTES  = 4;
  localparam int STAT_BYTES = 4;

  localparam logic [7:0] OP_ENABLE    = 8'hC6;
  localparam logic [7:0] OP_ERASE     = 8'h0E;
  localparam logic [7:0] OP_INIT_ADDR = 8'h46;
  localparam logic [7:0] OP_PROG_PAGE = 8'h70;
  localparam logic [7:0] OP_PROG_DONE = 8'h5E;
  localparam logic [7:0] OP_RD_STATUS = 8'h3C;
  localparam logic [7:0] OP_REFRESH   = 8'h79;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_CMD  = 3'd2;
  localparam logic [2:0] ERR_OVFL = 3'd6;

  typedef enum logic [1:0] {BOP_ERASE, BOP_PROGDONE, BOP_REFRESH} busy_op_e;

  function automatic logic [31:0] pack_status(logic dev_ver, logic [2:0] err, logic busy,
                                              logic en, logic done);
    logic [31:0] s;
    s          = '0;
    s[27]      = dev_ver;
    s[25:23]   = err;
    s[13]      = (err != ERR_NONE);
    s[12]      = busy;
    s[9]       = en;
    s[8]       = done;
    return s;
  endfunction
endpackage

// File: rtl/cfgport_frame_ctr.sv
module cfgport_frame_ctr #(
  parameter int MAX_LEN = 20,
  localparam int IW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rx_valid_i,
  output logic [IW-1:0] idx_o,
  output logic          frame_end_o
);
  logic [IW-1:0] idx_q;
  logic          cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      cs_q <= cs_i;
      if (!cs_i) idx_q <= '0;
      else if (rx_valid_i && idx_q != IW'(MAX_LEN)) idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o       = idx_q;
  assign frame_end_o = cs_q & ~cs_i;

  a_r12_idx_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> idx_q == '0);
endmodule

// File: rtl/cfgport_busy_timer.sv
module cfgport_busy_timer
  import cfgport_pkg::*;
#(
  parameter int ERASE_CYC   = 20,
  parameter int PROG_CYC    = 10,
  parameter int REFRESH_CYC = 30,
  localparam int MAXC = (ERASE_CYC > PROG_CYC)
                        ? ((ERASE_CYC > REFRESH_CYC) ? ERASE_CYC : REFRESH_CYC)
                        : ((PROG_CYC > REFRESH_CYC) ? PROG_CYC : REFRESH_CYC),
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  busy_op_e op_i,
  output logic     busy_o,
  output logic     expire_o,
  output busy_op_e op_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;
  busy_op_e      op_q;

  always_comb begin
    case (op_i)
      BOP_ERASE:    len = CW'(ERASE_CYC);
      BOP_PROGDONE: len = CW'(PROG_CYC);
      default:      len = CW'(REFRESH_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= BOP_ERASE;
    end else if (start_i) begin
      cnt_q <= len;
      op_q  <= op_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1));
  assign op_o     = op_q;

  a_r7_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r6_busy_ends_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/cfgport_status_tx.sv
module cfgport_status_tx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        load_i,
  input  logic [31:0] status_i,
  input  logic        shift_i,
  input  logic        last_i,
  output logic [7:0]  tx_byte_o
);
  logic [31:0] sh_q;
  logic        act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (!cs_i) begin
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= status_i;
      act_q <= 1'b1;
    end else if (shift_i && act_q) begin
      sh_q <= {sh_q[23:0], 8'h00};
      if (last_i) act_q <= 1'b0;
    end
  end

  assign tx_byte_o = act_q ? sh_q[31:24] : 8'h00;

  a_r4_quiet_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> tx_byte_o == 8'h00);
endmodule

// File: rtl/cfgport_target.sv
module cfgport_target
  import cfgport_pkg::*;
#(
  parameter int   PAGE_BYTES  = 16,
  parameter int   PAGE_AW     = 4,
  parameter int   ERASE_CYC   = 20,
  parameter int   PROG_CYC    = 10,
  parameter int   REFRESH_CYC = 30,
  parameter logic DEV_VER     = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_byte_i,
  output logic [7:0]              tx_byte_o,
  output logic                    mem_we_o,
  output logic [PAGE_AW-1:0]      mem_addr_o,
  output logic [PAGE_BYTES*8-1:0] mem_wdata_o,
  output logic                    mem_clr_o,
  output logic [31:0]             status_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    cfg_en_o,
  output logic [2:0]              err_o
);
  localparam int PROG_LEN = CMD_BYTES + PAGE_BYTES;
  localparam int RD_LEN   = CMD_BYTES + STAT_BYTES;
  localparam int IW       = $clog2(PROG_LEN + 1);
  localparam logic [IW-1:0] IDX_OP   = '0;
  localparam logic [IW-1:0] IDX_FIRE = IW'(CMD_BYTES - 1);
  localparam logic [IW-1:0] IDX_DATA = IW'(CMD_BYTES);
  localparam logic [IW-1:0] IDX_PEND = IW'(PROG_LEN - 1);
  localparam logic [IW-1:0] IDX_REND = IW'(RD_LEN - 1);

  logic [IW-1:0] idx, req_len, di;
  logic          frame_end, acc, cmd_fire;
  logic [7:0]    opc_q;
  logic          done_q, en_q, prog_ok_q;
  logic [2:0]    err_q;
  logic [PAGE_AW-1:0] page_q;

  logic     t_busy, t_expire, t_start;
  busy_op_e t_op, t_op_n;
  logic     cmd_err, do_enable, do_init, do_load, do_prog;
  logic     data_we, page_last;

  logic [7:0]              buf_q [PAGE_BYTES];
  logic [PAGE_BYTES*8-1:0] wdata_n, mem_wdata_q;
  logic                    mem_we_q, mem_clr_q;
  logic [PAGE_AW-1:0]      mem_addr_q;

  cfgport_frame_ctr #(.MAX_LEN(PROG_LEN)) u_frame (
    .clk_i, .rst_ni, .cs_i, .rx_valid_i,
    .idx_o(idx), .frame_end_o(frame_end)
  );

  cfgport_busy_timer #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .REFRESH_CYC(REFRESH_CYC)
  ) u_timer (
    .clk_i, .rst_ni, .start_i(t_start), .op_i(t_op_n),
    .busy_o(t_busy), .expire_o(t_expire), .op_o(t_op)
  );

  assign acc      = cs_i & rx_valid_i;
  assign cmd_fire = acc && (idx == IDX_FIRE);
  assign status_o = pack_status(DEV_VER, err_q, t_busy, en_q, done_q);

  cfgport_status_tx u_tx (
    .clk_i, .rst_ni, .cs_i, .load_i(do_load), .status_i(status_o),
    .shift_i(acc && idx >= IDX_DATA && idx <= IDX_REND),
    .last_i(idx == IDX_REND), .tx_byte_o
  );

  always_comb begin
    case (opc_q)
      OP_PROG_PAGE: req_len = IW'(PROG_LEN);
      OP_RD_STATUS: req_len = IW'(RD_LEN);
      default:      req_len = IW'(CMD_BYTES);
    endcase
  end

  // command decode at the 4th byte
  always_comb begin
    t_start = 1'b0; t_op_n = BOP_ERASE; cmd_err = 1'b0;
    do_enable = 1'b0; do_init = 1'b0; do_load = 1'b0; do_prog = 1'b0;
    if (cmd_fire) begin
      case (opc_q)
        OP_RD_STATUS: do_load = 1'b1;
        OP_ENABLE:    if (t_busy) cmd_err = 1'b1; else do_enable = 1'b1;
        OP_INIT_ADDR: if (t_busy) cmd_err = 1'b1; else do_init = 1'b1;
        OP_PROG_PAGE: if (t_busy || !en_q) cmd_err = 1'b1; else do_prog = 1'b1;
        OP_ERASE, OP_PROG_DONE, OP_REFRESH: begin
          if (t_busy || !en_q) cmd_err = 1'b1;
          else begin
            t_start = 1'b1;
            t_op_n  = (opc_q == OP_ERASE)     ? BOP_ERASE :
                      (opc_q == OP_PROG_DONE) ? BOP_PROGDONE : BOP_REFRESH;
          end
        end
        default: cmd_err = 1'b1;
      endcase
    end
  end

  assign di        = idx - IDX_DATA;
  assign data_we   = acc && prog_ok_q && idx >= IDX_DATA && idx <= IDX_PEND;
  assign page_last = data_we && (idx == IDX_PEND);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[g] <= '0;
      else if (data_we && di == IW'(g)) buf_q[g] <= rx_byte_i;
    end
    assign wdata_n[8*g +: 8] = (g == PAGE_BYTES - 1) ? rx_byte_i : buf_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0; done_q <= 1'b0; en_q <= 1'b0; err_q <= ERR_NONE;
      prog_ok_q <= 1'b0; page_q <= '0;
      mem_we_q <= 1'b0; mem_clr_q <= 1'b0; mem_addr_q <= '0; mem_wdata_q <= '0;
    end else begin
      mem_we_q  <= 1'b0;
      mem_clr_q <= 1'b0;
      if (acc && idx == IDX_OP) opc_q <= rx_byte_i;
      if (t_expire && t_op == BOP_PROGDONE) done_q <= 1'b1;
      if (t_expire && t_op == BOP_REFRESH)  en_q   <= 1'b0;
      if (frame_end && idx != '0 && idx < req_len) err_q <= ERR_OVFL;
      if (cmd_err) err_q <= ERR_CMD;
      if (do_enable) begin
        en_q  <= 1'b1;
        err_q <= ERR_NONE;
      end
      if (do_init) page_q <= '0;
      if (t_start && t_op_n == BOP_ERASE) begin
        mem_clr_q <= 1'b1;
        done_q    <= 1'b0;
      end
      if (!cs_i) prog_ok_q <= 1'b0;
      else if (do_prog) prog_ok_q <= 1'b1;
      if (page_last) begin
        mem_we_q    <= 1'b1;
        mem_addr_q  <= page_q;
        mem_wdata_q <= wdata_n;
        page_q      <= page_q + 1'b1;
      end
    end
  end

  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
  assign mem_clr_o   = mem_clr_q;
  assign busy_o      = t_busy;
  assign done_o      = done_q;
  assign cfg_en_o    = en_q;
  assign err_o       = err_q;

  a_r5_write_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cfg_en_o);
  a_r8_page_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> page_q == PAGE_AW'(mem_addr_o + 1'b1));
  a_r7_clear_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clr_o |-> busy_o && !done_o);
  a_r12_short_frame_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && idx != '0 && idx < req_len) |=> err_o == ERR_OVFL);
  a_r10_done_after_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(t_expire && t_op == BOP_PROGDONE));
endmodule

// File: tb/cfgport_target_tb.sv
module cfgport_target_tb;
  localparam int   CLK_PERIOD  = 10;
  localparam int   PAGE_BYTES  = 16;
  localparam int   PAGE_AW     = 4;
  localparam int   ERASE_CYC   = 20;
  localparam int   PROG_CYC    = 10;
  localparam int   REFRESH_CYC = 30;
  localparam logic DEV_VER     = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, vld = 1'b0;
  logic [7:0] dat = '0;
  logic [7:0] tx_byte;
  logic mem_we, mem_clr, busy, done, cfg_en;
  logic [PAGE_AW-1:0] mem_addr;
  logic [PAGE_BYTES*8-1:0] mem_wdata;
  logic [31:0] status;
  logic [2:0] err;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, clr_cnt = 0;
  logic [PAGE_AW-1:0] wr_addr;
  logic [PAGE_BYTES*8-1:0] wr_data;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_target #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .REFRESH_CYC(REFRESH_CYC), .DEV_VER(DEV_VER)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rx_valid_i(vld), .rx_byte_i(dat),
    .tx_byte_o(tx_byte), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_clr_o(mem_clr), .status_o(status),
    .busy_o(busy), .done_o(done), .cfg_en_o(cfg_en), .err_o(err)
  );

  always @(posedge clk) if (rst_n) begin
    if (mem_we) begin
      wr_cnt++;
      wr_addr = mem_addr;
      wr_data = mem_wdata;
    end
    if (mem_clr) clr_cnt++;
  end

  function automatic logic [31:0] st(logic d, logic e, logic b, logic [2:0] ec);
    logic [31:0] s = '0;
    s[27] = DEV_VER; s[25:23] = ec; s[13] = (ec != 0); s[12] = b; s[9] = e; s[8] = d;
    return s;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); cs = 1'b1; vld = 1'b1; dat = b;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_cmd(logic [7:0] op);
    send_byte(op); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    end_frame();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [7:0] pat(int p, int k);
    return 8'((p << 4) ^ (k * 7) ^ 8'h5A);
  endfunction

  task automatic send_page(int p);
    send_byte(8'h70); send_byte(8'h00); send_byte(8'h00); send_byte(8'h01);
    for (int k = 0; k < PAGE_BYTES; k++) send_byte(pat(p, k));
    end_frame();
  endtask

  function automatic logic [PAGE_BYTES*8-1:0] page_exp(int p);
    logic [PAGE_BYTES*8-1:0] v;
    for (int k = 0; k < PAGE_BYTES; k++) v[8*k +: 8] = pat(p, k);
    return v;
  endfunction

  task automatic test_reset();
    chk("R1 status", status, st(0, 0, 0, 3'd0));
    chk("R1 tx", tx_byte, 8'h00);
    chk("R1 writes", wr_cnt + clr_cnt, 0);
  endtask

  task automatic test_gate();
    send_cmd(8'h0E);
    chk("R5 erase refused", status, st(0, 0, 0, 3'd2));
    chk("R5 no clear", clr_cnt, 0);
    send_page(9);
    chk("R5 program refused", wr_cnt, 0);
    send_cmd(8'hC6);
    chk("R5 enable", status, st(0, 1, 0, 3'd0));
    send_cmd(8'hA5);
    chk("R2 unknown opcode", err, 3'd2);
    chk("R3 fail bit", status[13], 1'b1);
    send_cmd(8'hC6);
    chk("R5 enable clears err", err, 3'd0);
  endtask

  task automatic test_read();
    logic [31:0] v = '0;
    send_byte(8'h3C); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    for (int i = 0; i < 4; i++) begin
      v = {v[23:0], tx_byte};
      send_byte(8'hFF);
    end
    chk("R4 tx after last", tx_byte, 8'h00);
    end_frame();
    chk("R4 read status", v, st(0, 1, 0, 3'd0));
    chk("R3 layout", status, 32'h0800_0200);
  endtask

  task automatic test_erase();
    int n;
    send_byte(8'h0E); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    chk("R7 busy bit", status[12], 1'b1);
    wait_idle(n);
    chk("R7 busy length", n, ERASE_CYC);
    chk("R7 clear pulse", clr_cnt, 1);
    chk("R7 done low", done, 1'b0);
    end_frame();
    send_cmd(8'h0E);
    send_cmd(8'h79);
    chk("R6 refused while busy", err, 3'd2);
    wait_idle(n);
    chk("R6 refresh dropped", cfg_en, 1'b1);
    send_cmd(8'hC6);
  endtask

  task automatic test_program();
    send_cmd(8'h46);
    send_page(0);
    chk("R8 write count", wr_cnt, 1);
    chk("R8 addr p0", wr_addr, 0);
    chk("R8 data p0", wr_data, page_exp(0));
    send_page(1);
    chk("R8 addr p1", wr_addr, 1);
    chk("R8 data p1", wr_data, page_exp(1));
    send_byte(8'h70); for (int k = 0; k < 9; k++) send_byte(8'h11);
    end_frame();
    chk("R12 short err", err, 3'd6);
    chk("R12 no write", wr_cnt, 2);
    send_cmd(8'hC6);
    @(negedge clk); cs = 1'b1; @(negedge clk); cs = 1'b0; @(negedge clk);
    chk("R12 empty frame", err, 3'd0);
    send_byte(8'h46); send_byte(8'h00); end_frame();
    chk("R12 short cmd err", err, 3'd6);
    send_cmd(8'hC6);
    send_page(2);
    chk("R12 page kept", wr_addr, 2);
    send_cmd(8'h46);
    send_page(3);
    chk("R9 init address", wr_addr, 0);
    chk("R8 data p3", wr_data, page_exp(3));
  endtask

  task automatic test_done_refresh();
    int n;
    send_byte(8'h5E); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    wait_idle(n);
    chk("R10 busy length", n, PROG_CYC);
    chk("R10 done", done, 1'b1);
    end_frame();
    send_byte(8'h79); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    wait_idle(n);
    chk("R11 busy length", n, REFRESH_CYC);
    chk("R11 status", status, st(1, 0, 0, 3'd0));
    end_frame();
  endtask

  task automatic test_collide();
    send_cmd(8'hC6);
    send_byte(8'h79); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    cs = 1'b0;
    @(negedge clk); cs = 1'b1; vld = 1'b1; dat = 8'h46;
    @(negedge clk); vld = 1'b0;
    repeat (REFRESH_CYC - 3) @(negedge clk);
    chk("R13 busy before edge", busy, 1'b1);
    cs = 1'b0;
    @(negedge clk);
    chk("R13 both applied", status, st(1, 0, 0, 3'd6));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_gate();
    test_read();
    test_erase();
    test_program();
    test_done_refresh();
    test_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule